// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for every received CAN frame header, whether the frame is kept and which of two receive queues it goes to. It holds a parameterised number of filter banks. Each bank has two 32-bit pattern registers and four control bits: list or mask matching, 32-bit or 16-bit entries, target queue, and enable. The control bits change how the two registers are read. One bank can act as one masked 32-bit filter, two exact 32-bit identifiers, two masked 16-bit filters or four exact 16-bit identifiers.

Software programs the banks through a simple word-write port. A master register holds a global hold bit and a bank split point. The split point shares the banks between two controllers that send headers to the filter. The block gives one registered result per header: accept, target queue and the number of the entry that matched.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the hold bit is set, every bank is disabled and res_valid, res_accept, res_fifo and res_index are all 0. A header sent before any configuration is rejected.
- R2: Each header strobed with rx_valid yields exactly one result with res_valid high one clock later. res_valid is never high without a header one cycle earlier.
- R3: Frame word for 32-bit entries: the 29-bit identifier occupies bits 31:3, IDE bit 2, RTR bit 1 and bit 0 is 0. A standard frame's 11-bit identifier (rx_id[10:0]) sits in bits 31:21 with bits 20:3 zero.
- R4: Frame word for 16-bit entries: standard identifier in bits 15:5, RTR bit 4, IDE bit 3, extended identifier bits 17:15 in bits 2:0. For standard frames bits 2:0 are 0.
- R5: Bank with list=1 and wide=1: entry 0 is register A and entry 1 is register B. Each entry matches only on full 32-bit equality with the frame word.
- R6: Bank with list=0 and wide=1: one entry. Register A is the identifier and register B the mask. It matches when ((word XOR A) AND B) is 0.
- R7: Bank with list=0 and wide=0: entry 0 takes its mask from A[31:16] and its identifier from A[15:0]; entry 1 is the same with B. An entry matches when its masked 16-bit difference is 0.
- R8: Bank with list=1 and wide=0: four exact 16-bit entries, in the order A[15:0], A[31:16], B[15:0], B[31:16].
- R9: A disabled bank never matches.
- R10: res_fifo equals the queue bit of the winning bank.
- R11: With split value S, rx_ctrl=0 uses banks 0..S-1 and rx_ctrl=1 uses banks S..NUM_BANKS-1. The index counts from the first bank of that range.
- R12: The lowest matching bank wins, and within it the lowest entry. res_index is the entry number plus the entry counts (1, 2, 2 or 4) of all lower banks in the range, whether those banks are enabled or not.
- R13: While the hold bit is set, every header is rejected.
- R14: A rejected header gives res_accept=0, res_fifo=0 and res_index=0.

Register map (word address on cfg_addr): 0 master (bit 0 hold, bits 13:8 split). 1 list bits, 2 wide bits, 3 queue bits, 4 enable bits (bit b is bank b). 8+2b is register A of bank b and 9+2b is register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Header strobe |
| rx_ctrl | input | 1 | Controller that owns the header (selects the bank range) |
| rx_id | input | 29 | Identifier; standard frames use bits 10:0 |
| rx_ide | input | 1 | Extended-identifier flag |
| rx_rtr | input | 1 | Remote-request flag |
| res_valid | output | 1 | Result strobe, one cycle after rx_valid |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Target receive queue |
| res_index | output | IDX_W | Number of the matching entry |

## Verification
Every 11-bit standard identifier is swept with both RTR values and both controllers under four bank setups. The setups switch each bank between all four entry interpretations, move the split point to 0, the middle and the top, and disable a bank. This separates bit-layout errors, mask and list mix-ups and wrong priority or index arithmetic. A sweep of extended identifiers around the programmed values tests the extended-bit field of the 16-bit layout and the IDE and RTR compare in the 32-bit layout. A final sweep with the hold bit set must reject everything.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int ADDR_MASTER = 0;
    localparam int ADDR_LIST   = 1;
    localparam int ADDR_WIDE   = 2;
    localparam int ADDR_FIFO   = 3;
    localparam int ADDR_ACT    = 4;
    localparam int ADDR_BANK0  = 8;
    localparam int ENT_MAX     = 4;

    typedef struct packed {
        logic [28:0] id;
        logic        ide;
        logic        rtr;
    } rx_hdr_t;

    typedef struct packed {
        logic        list;
        logic        wide;
        logic        fifo;
        logic        act;
        logic [31:0] ra;
        logic [31:0] rb;
    } bank_cfg_t;

    function automatic logic [28:0] full_id(rx_hdr_t h);
        return h.ide ? h.id : {h.id[10:0], 18'd0};
    endfunction

    function automatic logic [31:0] frame_word32(rx_hdr_t h);
        return {full_id(h), h.ide, h.rtr, 1'b0};
    endfunction

    function automatic logic [15:0] frame_word16(rx_hdr_t h);
        logic [28:0] f;
        f = full_id(h);
        return {f[28:18], h.rtr, h.ide, f[17:15]};
    endfunction

    function automatic logic [2:0] entry_count(logic list, logic wide);
        case ({wide, list})
            2'b10:   return 3'd1;
            2'b11:   return 3'd2;
            2'b00:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/canf_cfg_regs.sv
module canf_cfg_regs
    import can_filt_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [31:0]          wdata,
    output bank_cfg_t [NB-1:0]   cfg,
    output logic                 hold_q,
    output logic [5:0]           split_q
);
    localparam logic [5:0] SPLIT_RST = 6'(NB / 2);

    logic [NB-1:0] list_q, wide_q, fifo_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= 1'b1;
            split_q <= SPLIT_RST;
            list_q  <= '0;
            wide_q  <= '0;
            fifo_q  <= '0;
            act_q   <= '0;
        end else if (we) begin
            case (int'(addr))
                ADDR_MASTER: begin
                    hold_q  <= wdata[0];
                    split_q <= wdata[13:8];
                end
                ADDR_LIST: list_q <= wdata[NB-1:0];
                ADDR_WIDE: wide_q <= wdata[NB-1:0];
                ADDR_FIFO: fifo_q <= wdata[NB-1:0];
                ADDR_ACT:  act_q  <= wdata[NB-1:0];
                default: ;
            endcase
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [31:0] ra_q, rb_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ra_q <= '0;
                rb_q <= '0;
            end else if (we && int'(addr) == ADDR_BANK0 + 2*b) begin
                ra_q <= wdata;
            end else if (we && int'(addr) == ADDR_BANK0 + 2*b + 1) begin
                rb_q <= wdata;
            end
        end
        assign cfg[b] = '{list: list_q[b], wide: wide_q[b], fifo: fifo_q[b],
                          act: act_q[b], ra: ra_q, rb: rb_q};
    end
endmodule

// File: rtl/canf_bank_match.sv
module canf_bank_match
    import can_filt_pkg::*;
(
    input  bank_cfg_t          cfg,
    input  logic [31:0]        w32,
    input  logic [15:0]        w16,
    output logic [ENT_MAX-1:0] hit
);
    logic [ENT_MAX-1:0] raw;

    always_comb begin
        raw = '0;
        case ({cfg.wide, cfg.list})
            2'b11: begin
                raw[0] = (w32 == cfg.ra);
                raw[1] = (w32 == cfg.rb);
            end
            2'b10: begin
                raw[0] = (((w32 ^ cfg.ra) & cfg.rb) == 32'd0);
            end
            2'b01: begin
                raw[0] = (w16 == cfg.ra[15:0]);
                raw[1] = (w16 == cfg.ra[31:16]);
                raw[2] = (w16 == cfg.rb[15:0]);
                raw[3] = (w16 == cfg.rb[31:16]);
            end
            default: begin
                raw[0] = (((w16 ^ cfg.ra[15:0]) & cfg.ra[31:16]) == 16'd0);
                raw[1] = (((w16 ^ cfg.rb[15:0]) & cfg.rb[31:16]) == 16'd0);
            end
        endcase
        hit = cfg.act ? raw : '0;
    end
endmodule

// File: rtl/canf_pick.sv
module canf_pick
    import can_filt_pkg::*;
#(
    parameter int NB = 4,
    parameter int IW = 4
) (
    input  bank_cfg_t [NB-1:0]          cfg,
    input  logic [NB-1:0][ENT_MAX-1:0]  hits,
    input  logic                        ctrl,
    input  logic [5:0]                  split,
    output logic                        found,
    output logic                        fifo,
    output logic [IW-1:0]               index
);
    logic [IW:0] acc;
    logic [2:0]  ent;
    logic        in_range;

    always_comb begin
        found = 1'b0;
        fifo  = 1'b0;
        index = '0;
        acc   = '0;
        ent   = '0;
        for (int b = 0; b < NB; b++) begin
            in_range = ctrl ? (b >= int'(split)) : (b < int'(split));
            if (in_range && !found) begin
                if (|hits[b]) begin
                    for (int e = ENT_MAX - 1; e >= 0; e--)
                        if (hits[b][e]) ent = 3'(e);
                    found = 1'b1;
                    fifo  = cfg[b].fifo;
                    index = IW'(acc + (IW+1)'(ent));
                end else begin
                    acc = acc + (IW+1)'(entry_count(cfg[b].list, cfg[b].wide));
                end
            end
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int ADDR_W    = $clog2(ADDR_BANK0 + 2*NUM_BANKS),
    localparam int IDX_W     = $clog2(ENT_MAX*NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_ctrl,
    input  logic [28:0]       rx_id,
    input  logic              rx_ide,
    input  logic              rx_rtr,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_fifo,
    output logic [IDX_W-1:0]  res_index
);
    bank_cfg_t [NUM_BANKS-1:0]          cfg;
    logic                               hold_q;
    logic [5:0]                         split_q;
    logic [NUM_BANKS-1:0][ENT_MAX-1:0]  hits;
    rx_hdr_t                            hdr;
    logic [31:0]                        w32;
    logic [15:0]                        w16;
    logic                               found, pick_fifo;
    logic [IDX_W-1:0]                   pick_idx;

    assign hdr = '{id: rx_id, ide: rx_ide, rtr: rx_rtr};
    assign w32 = frame_word32(hdr);
    assign w16 = frame_word16(hdr);

    canf_cfg_regs #(.NB(NUM_BANKS), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .hold_q(hold_q), .split_q(split_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        canf_bank_match u_match (
            .cfg(cfg[b]), .w32(w32), .w16(w16), .hit(hits[b])
        );
    end

    canf_pick #(.NB(NUM_BANKS), .IW(IDX_W)) u_pick (
        .cfg(cfg), .hits(hits), .ctrl(rx_ctrl), .split(split_q),
        .found(found), .fifo(pick_fifo), .index(pick_idx)
    );

    logic take;
    assign take = rx_valid && found && !hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_fifo   <= 1'b0;
            res_index  <= '0;
        end else begin
            res_valid  <= rx_valid;
            res_accept <= take;
            res_fifo   <= take ? pick_fifo : 1'b0;
            res_index  <= take ? pick_idx : '0;
        end
    end
endmodule

// File: rtl/canf_chk.sv
module canf_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          hold_q,
    input logic          res_valid,
    input logic          res_accept,
    input logic          res_fifo,
    input logic [IW-1:0] res_index
);
    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> res_valid);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(rx_valid));

    // R13
    hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> !$past(hold_q));

    // R14
    reject_clean_chk: assert property (@(posedge clk) disable iff (rst)
        !res_accept |-> (!res_fifo && res_index == '0));

    // R2
    accept_in_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> res_valid);
endmodule

bind can_accept_filter canf_chk #(.IW(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .hold_q(hold_q),
    .res_valid(res_valid), .res_accept(res_accept), .res_fifo(res_fifo),
    .res_index(res_index)
);

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
    localparam int NB = 4;
    localparam int AW = 5;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic rx_valid = 1'b0, rx_ctrl = 1'b0, rx_ide = 1'b0, rx_rtr = 1'b0;
    logic [28:0] rx_id = '0;
    logic res_valid, res_accept, res_fifo;
    logic [IW-1:0] res_index;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_a [NB];
    logic [31:0] m_b [NB];
    logic [NB-1:0] m_list = '0, m_wide = '0, m_fifo = '0, m_act = '0;
    logic m_hold = 1'b1;
    int   m_split = NB / 2;

    always #5 clk = ~clk;

    can_accept_filter #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
        .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
        .res_valid(res_valid), .res_accept(res_accept),
        .res_fifo(res_fifo), .res_index(res_index)
    );

    function automatic logic [31:0] v32(logic [28:0] id, logic ide, logic rtr);
        return {id, ide, rtr, 1'b0};
    endfunction
    function automatic logic [15:0] v16(logic [10:0] s, logic rtr, logic ide, logic [2:0] x);
        return {s, rtr, ide, x};
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: begin m_hold = d[0]; m_split = int'(d[13:8]); end
            1: m_list = d[NB-1:0];
            2: m_wide = d[NB-1:0];
            3: m_fifo = d[NB-1:0];
            4: m_act  = d[NB-1:0];
            default: if (a[0]) m_b[(a-8)/2] = d; else m_a[(a-8)/2] = d;
        endcase
    endtask

    // expected result from the requirement text (R3..R12)
    task automatic model(input logic ctrl, input logic [28:0] id, input logic ide,
                         input logic rtr, output logic acc, output logic fq,
                         output int idx);
        logic [28:0] f;
        logic [31:0] w32, pid, pmk;
        logic [15:0] w16;
        int base, n;
        bit hit;
        f   = ide ? id : {id[10:0], 18'd0};
        w32 = {f, ide, rtr, 1'b0};
        w16 = {f[28:18], rtr, ide, f[17:15]};
        acc = 0; fq = 0; idx = 0; base = 0;
        for (int b = 0; b < NB; b++) begin
            if (acc) break;
            if ((ctrl == 1'b0 && b >= m_split) || (ctrl == 1'b1 && b < m_split)) continue;
            n = m_wide[b] ? (m_list[b] ? 2 : 1) : (m_list[b] ? 4 : 2);
            for (int e = 0; e < n; e++) begin
                if (m_wide[b]) begin
                    pid = (m_list[b] && e == 1) ? m_b[b] : m_a[b];
                    pmk = m_list[b] ? 32'hFFFF_FFFF : m_b[b];
                    hit = ((w32 ^ pid) & pmk) == 0;
                end else if (m_list[b]) begin
                    pid = (e < 2) ? m_a[b] : m_b[b];
                    hit = (e % 2 == 0) ? (w16 == pid[15:0]) : (w16 == pid[31:16]);
                end else begin
                    pid = (e == 0) ? m_a[b] : m_b[b];
                    hit = ((w16 ^ pid[15:0]) & pid[31:16]) == 0;
                end
                if (hit && m_act[b] && !m_hold && !acc) begin
                    acc = 1; fq = m_fifo[b]; idx = base + e;
                end
            end
            base += n;
        end
    endtask

    task automatic frame(logic ctrl, logic [28:0] id, logic ide, logic rtr, string tag);
        logic ea, ef;
        int ei;
        model(ctrl, id, ide, rtr, ea, ef, ei);
        @(negedge clk);
        rx_valid = 1'b1; rx_ctrl = ctrl; rx_id = id; rx_ide = ide; rx_rtr = rtr;
        @(negedge clk);
        rx_valid = 1'b0;
        checks++;
        if (res_valid !== 1'b1 || res_accept !== ea || res_fifo !== ef ||
            int'(res_index) != ei) begin
            fails++;
            $display("FAIL %s ctrl=%0d id=%h ide=%0d rtr=%0d: got v=%0d a=%0d f=%0d i=%0d exp v=1 a=%0d f=%0d i=%0d",
                     tag, ctrl, id, ide, rtr, res_valid, res_accept, res_fifo,
                     res_index, ea, ef, ei);
        end
    endtask

    task automatic sweep_std(string tag);
        for (int s = 0; s < 2048; s++)
            for (int k = 0; k < 4; k++)
                frame(k[1], 29'(s), 1'b0, k[0], tag);
    endtask

    task automatic sweep_ext(string tag);
        for (int k = 0; k < 256; k++) begin
            frame(k[0], {11'h050, k[3:1], 15'(k * 37)}, 1'b1, 1'b0, tag);
            frame(k[0], 29'h1234567 ^ 29'(k >> 1), 1'b1, k[1], tag);
            frame(k[0], {11'h123, 18'(k)}, 1'b1, 1'b0, tag);
        end
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_a[b] = '0; m_b[b] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state of the outputs
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0 || res_fifo !== 1'b0 || res_index !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs got %0d%0d%0d%0d exp 0000",
                     res_valid, res_accept, res_fifo, res_index);
        end
        frame(1'b0, 29'h0, 1'b0, 1'b0, "R1");
        frame(1'b1, 29'h123, 1'b0, 1'b0, "R1");

        // setup A: one bank of each kind, split 2
        wr(8,  v32(29'h1234567, 1'b1, 1'b0));
        wr(9,  v32({11'h123, 18'd0}, 1'b0, 1'b0));
        wr(10, v32({11'h120, 18'd0}, 1'b0, 1'b0));
        wr(11, v32({11'h7F0, 18'd0}, 1'b1, 1'b1));
        wr(12, {v16(11'h201, 1'b1, 1'b0, 3'd0), v16(11'h200, 1'b0, 1'b0, 3'd0)});
        wr(13, {v16(11'h7FF, 1'b0, 1'b0, 3'd0), v16(11'h202, 1'b0, 1'b0, 3'd0)});
        wr(14, {v16(11'h700, 1'b1, 1'b1, 3'd0), v16(11'h300, 1'b0, 1'b0, 3'd0)});
        wr(15, {v16(11'h7FF, 1'b1, 1'b1, 3'd7), v16(11'h050, 1'b0, 1'b1, 3'd5)});
        wr(1, 32'b0101);
        wr(2, 32'b0011);
        wr(3, 32'b1010);
        wr(4, 32'b1111);
        // R13 hold still set: nothing accepted
        frame(1'b0, 29'h123, 1'b0, 1'b0, "R13");
        wr(0, 32'h0000_0200);
        sweep_std("R3 R4 R5 R6 R7 R8 R10 R11 R12 R14");
        sweep_ext("R3 R4 R5 R7");

        // setup B: split 0, bank 1 now 16-bit mask, bank 0 disabled
        wr(2, 32'b0001);
        wr(3, 32'b0101);
        wr(4, 32'b1110);
        wr(0, 32'h0000_0000);
        sweep_std("R7 R9 R10 R11 R12");

        // setup C: split at top, all banks read as four exact 16-bit ids
        wr(1, 32'b1111);
        wr(2, 32'b0000);
        wr(4, 32'b1111);
        wr(0, 32'h0000_0400);
        sweep_std("R8 R11 R12");
        sweep_ext("R4 R8");

        // setup D: hold set again
        wr(0, 32'h0000_0201);
        for (int s = 0; s < 2048; s += 7)
            frame(s[0], 29'(s), 1'b0, 1'b0, "R13");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule